// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block sits between the memory array of a synchronous SRAM and its data pins. Each clock cycle it is told what kind of cycle the input registers captured (read, write or deselect) and, on a read, receives the word read from the array in that same cycle. From these it produces the word placed on the data bus and the enable for the tri-state drivers.

Two mode inputs shape the timing, and both may change at run time. The first picks pipelined output, where one rising-edge register sits between the array and the pins, or flow-through output, where array data goes straight to the pins. The second picks how long the drivers stay on after a deselect. With single-cycle deselect they stop at the same point the read data would have ended. With dual-cycle deselect a deselect that follows a read holds the last word on the bus for one more cycle. The drive enable goes through the same number of register stages as the data, so the two stay aligned in both output modes.

The drivers can also be switched off without waiting for a clock. This happens when the active-low output enable is high, when the sleep input is high, while reset is asserted, and during every write cycle.

Top module: `sram_rdout_stage`

## Requirements
- R1: While `rst_n` is low, `dq_drive` is 0. In pipelined mode `dq_out` is 0 during reset and stays 0 until the first read.
- R2: `cyc_kind` uses these codes: 2'b00 deselect, 2'b01 read, 2'b10 write. Code 2'b11 is treated exactly like a deselect.
- R3: Pipelined mode (`pipe_mode`=1): the `array_q` word of a read cycle appears on `dq_out` with `dq_drive`=1 in the next cycle. Back-to-back reads deliver one word per cycle. In the read cycle itself, no earlier read being pending, `dq_drive` is 0.
- R4: Flow-through mode (`pipe_mode`=0): the `array_q` word of a read cycle is on `dq_out` with `dq_drive`=1 in that same cycle.
- R5: Single-cycle deselect (`scd_mode`=1): in pipelined mode `dq_drive` is 0 in the cycle after any non-read cycle. In flow-through mode it is 0 in every non-read cycle.
- R6: Dual-cycle deselect (`scd_mode`=0): a deselect directly after a read keeps `dq_drive`=1 and the last read word on `dq_out` for one cycle beyond the point given in R5. Drive then turns off.
- R7: `dq_drive` is 0 during every write cycle. This includes a pipelined output slot of an earlier read and the hold cycle of R6, and a write never starts a hold cycle.
- R8: `oe_n`=1 forces `dq_drive` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the drive within the same cycle, but only in a cycle that carries read data.
- R9: `sleep`=1 forces `dq_drive` to 0 at once. Returning it to 0 restores a pending read output within the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_kind | input | 2 | Registered cycle type of the current cycle (R2 codes) |
| array_q | input | DW | Word read from the array in a read cycle |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| scd_mode | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high; disables drivers |
| dq_out | output | DW | Data presented to the pin drivers |
| dq_drive | output | 1 | Tri-state driver enable, active high |

## Verification
In pipelined mode, a read's output slot can land in a write cycle. In dual-cycle deselect, the extra hold cycle can also meet a write. In both cases the scheduled drive and the write gate both act on `dq_drive` in the same cycle. The bench provokes this with a read followed at once by a write, in both output modes. It requires the drive to be off in the write cycle and to stay off afterwards, with no hold cycle. In a second collision, `oe_n` is toggled inside a cycle that carries pipelined read data, and the bench checks that the drive follows it without a clock edge.

// File: rtl/srout_pkg.sv
package srout_pkg;

  localparam logic [1:0] KIND_IDLE  = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  function automatic logic kind_is_read(input logic [1:0] k);
    return k == KIND_READ;
  endfunction

  function automatic logic kind_is_write(input logic [1:0] k);
    return k == KIND_WRITE;
  endfunction

  // deselect covers the idle code and the spare code
  function automatic logic kind_is_desel(input logic [1:0] k);
    return !(kind_is_read(k) || kind_is_write(k));
  endfunction

  // driver wanted at an output stage: a read there, or a dual-deselect hold
  function automatic logic drive_wanted(input logic rd, input logic desel,
                                        input logic prev_rd, input logic dual);
    return rd | (dual & desel & prev_rd);
  endfunction

endpackage

// File: rtl/srout_enable_path.sv
module srout_enable_path (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_now,
  input  logic desel_now,
  input  logic pipe_mode,
  input  logic dual_mode,
  output logic drive_raw
);
  import srout_pkg::*;

  logic rd_q, desel_q, rd_qq;
  logic stage_rd, stage_desel, stage_prev_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      desel_q <= 1'b0;
      rd_qq   <= 1'b0;
    end else begin
      rd_q    <= rd_now;
      desel_q <= desel_now;
      rd_qq   <= rd_q;
    end
  end

  // taps shift by one stage in pipelined mode, same as the data path
  always_comb begin
    if (pipe_mode) begin
      stage_rd      = rd_q;
      stage_desel   = desel_q;
      stage_prev_rd = rd_qq;
    end else begin
      stage_rd      = rd_now;
      stage_desel   = desel_now;
      stage_prev_rd = rd_q;
    end
    drive_raw = drive_wanted(stage_rd, stage_desel, stage_prev_rd, dual_mode);
  end

endmodule

// File: rtl/srout_data_path.sv
module srout_data_path #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_now,
  input  logic          pipe_mode,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] dq_out
);
  logic [DW-1:0] out_q;

  // output register doubles as the hold for dual-deselect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (rd_now) out_q <= array_q;
  end

  assign dq_out = (!pipe_mode && rd_now) ? array_q : out_q;

endmodule

// File: rtl/srout_drive_gate.sv
module srout_drive_gate (
  input  logic rst_n,
  input  logic drive_raw,
  input  logic write_now,
  input  logic oe_n,
  input  logic sleep,
  output logic dq_drive
);
  logic gate_open;

  assign gate_open = rst_n & ~write_now & ~oe_n & ~sleep;
  assign dq_drive  = drive_raw & gate_open;

endmodule

// File: rtl/sram_rdout_stage.sv
module sram_rdout_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_kind,
  input  logic [DW-1:0] array_q,
  input  logic          pipe_mode,
  input  logic          scd_mode,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive
);
  import srout_pkg::*;

  logic rd_now, desel_now, write_now, dual_mode, drive_raw;

  assign rd_now    = kind_is_read(cyc_kind);
  assign desel_now = kind_is_desel(cyc_kind);
  assign write_now = kind_is_write(cyc_kind);
  assign dual_mode = ~scd_mode;

  srout_enable_path u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_now    (rd_now),
    .desel_now (desel_now),
    .pipe_mode (pipe_mode),
    .dual_mode (dual_mode),
    .drive_raw (drive_raw)
  );

  srout_data_path #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_now    (rd_now),
    .pipe_mode (pipe_mode),
    .array_q   (array_q),
    .dq_out    (dq_out)
  );

  srout_drive_gate u_gate (
    .rst_n     (rst_n),
    .drive_raw (drive_raw),
    .write_now (write_now),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dq_drive  (dq_drive)
  );

endmodule

// File: rtl/sram_rdout_stage_chk.sv
module sram_rdout_stage_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cyc_kind,
  input logic [DW-1:0] array_q,
  input logic          pipe_mode,
  input logic          scd_mode,
  input logic          oe_n,
  input logic          sleep,
  input logic [DW-1:0] dq_out,
  input logic          dq_drive
);
  localparam logic [1:0] K_IDLE  = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;
  localparam logic [1:0] K_SPARE = 2'b11;

  logic gates_open;
  assign gates_open = !oe_n && !sleep && (cyc_kind != K_WRITE);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> !dq_drive);

  // R3
  pipe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pipe_mode && $past(pipe_mode) && $past(cyc_kind) == K_READ && gates_open)
    |-> (dq_drive && dq_out == $past(array_q)));

  // R4
  ft_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cyc_kind == K_READ && !oe_n && !sleep)
    |-> (dq_drive && dq_out == array_q));

  // R5
  scd_pipe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pipe_mode && $past(pipe_mode) && scd_mode && $past(cyc_kind) != K_READ)
    |-> !dq_drive);

  // R5
  scd_ft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && scd_mode && cyc_kind != K_READ) |-> !dq_drive);

  // R6
  dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2) && !scd_mode &&
     $past(cyc_kind, 2) == K_READ &&
     ($past(cyc_kind) == K_IDLE || $past(cyc_kind) == K_SPARE) && gates_open)
    |-> (dq_drive && dq_out == $past(array_q, 2)));

  // R7
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_WRITE) |-> !dq_drive);

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dq_drive);

  // R9
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !dq_drive);

endmodule

bind sram_rdout_stage sram_rdout_stage_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_kind  (cyc_kind),
  .array_q   (array_q),
  .pipe_mode (pipe_mode),
  .scd_mode  (scd_mode),
  .oe_n      (oe_n),
  .sleep     (sleep),
  .dq_out    (dq_out),
  .dq_drive  (dq_drive)
);

// File: tb/sram_rdout_stage_test.sv
module sram_rdout_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;

  localparam logic [1:0] K_IDLE  = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;
  localparam logic [1:0] K_SPARE = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cyc_kind = K_IDLE;
  logic [DW-1:0] array_q = '0;
  logic          pipe_mode = 1'b1;
  logic          scd_mode = 1'b1;
  logic          oe_n = 1'b0;
  logic          sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  sram_rdout_stage #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .array_q(array_q),
    .pipe_mode(pipe_mode), .scd_mode(scd_mode), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // apply a cycle at the falling edge, then settle a quarter period
  task automatic step(input logic [1:0] k, input logic [DW-1:0] d);
    @(negedge clk);
    cyc_kind = k;
    array_q  = d;
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input logic exp_drive, input logic [DW-1:0] exp_data,
                     input bit check_data, input string tag);
    checks++;
    if (dq_drive !== exp_drive || (check_data && dq_out !== exp_data)) begin
      failures++;
      $display("FAIL %s drive=%0b exp=%0b data=%h exp=%h", tag, dq_drive, exp_drive,
               dq_out, exp_data);
    end
  endtask

  task automatic set_modes(input logic pm, input logic sm);
    @(negedge clk);
    pipe_mode = pm; scd_mode = sm; oe_n = 1'b0; sleep = 1'b0;
    cyc_kind = K_IDLE;
    for (int i = 0; i < 3; i++) step(K_IDLE, '0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(K_IDLE, 36'h0AAAAAAAA);
    chk(1'b0, '0, 1, "R1 reset idle");
    pipe_mode = 1'b0;
    step(K_READ, 36'h123456789);
    chk(1'b0, '0, 0, "R1 reset read in flow-through");
    pipe_mode = 1'b1;
    step(K_IDLE, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(K_IDLE, '0);
    chk(1'b0, '0, 1, "R1 after reset");
  endtask

  task automatic t_pipe_scd;
    set_modes(1'b1, 1'b1);
    step(K_READ, 36'h111111111); chk(1'b0, '0, 0, "R3 first read latency");
    step(K_READ, 36'h222222222); chk(1'b1, 36'h111111111, 1, "R3 word A");
    step(K_READ, 36'h333333333); chk(1'b1, 36'h222222222, 1, "R3 word B");
    step(K_IDLE, '0);            chk(1'b1, 36'h333333333, 1, "R3 word C");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R5 pipelined off");
  endtask

  task automatic t_pipe_dcd;
    set_modes(1'b1, 1'b0);
    step(K_READ, 36'h4A4A4A4A4); chk(1'b0, '0, 0, "R3 dcd latency");
    step(K_IDLE, '0);            chk(1'b1, 36'h4A4A4A4A4, 1, "R3 dcd output slot");
    step(K_IDLE, '0);            chk(1'b1, 36'h4A4A4A4A4, 1, "R6 pipelined hold");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R6 pipelined off after hold");
  endtask

  task automatic t_ft_scd;
    set_modes(1'b0, 1'b1);
    step(K_READ, 36'h5B5B5B5B5); chk(1'b1, 36'h5B5B5B5B5, 1, "R4 same-cycle A");
    step(K_READ, 36'h6C6C6C6C6); chk(1'b1, 36'h6C6C6C6C6, 1, "R4 same-cycle B");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R5 flow-through off");
  endtask

  task automatic t_ft_dcd;
    set_modes(1'b0, 1'b0);
    step(K_READ, 36'h7D7D7D7D7); chk(1'b1, 36'h7D7D7D7D7, 1, "R4 dcd read");
    step(K_SPARE, 36'hFFFFFFFFF); chk(1'b1, 36'h7D7D7D7D7, 1, "R2 spare code holds as deselect R6");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R6 flow-through off after hold");
  endtask

  task automatic t_write;
    set_modes(1'b1, 1'b0);
    step(K_READ, 36'h8E8E8E8E8);
    step(K_WRITE, 36'h0);        chk(1'b0, '0, 0, "R7 write over pipelined slot");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R7 no hold after write");
    set_modes(1'b0, 1'b0);
    step(K_READ, 36'h9F9F9F9F9);
    step(K_WRITE, 36'h0);        chk(1'b0, '0, 0, "R7 write in flow-through dcd");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R7 flow-through no hold");
  endtask

  task automatic t_oe;
    set_modes(1'b1, 1'b1);
    step(K_READ, 36'hA0A0A0A0A);
    @(negedge clk);
    oe_n = 1'b1; cyc_kind = K_READ; array_q = 36'hB1B1B1B1B;
    #(CLK_PERIOD/4);
    chk(1'b0, '0, 0, "R8 oe high blocks");
    oe_n = 1'b0; #1;
    chk(1'b1, 36'hA0A0A0A0A, 1, "R8 oe low restores without clock");
    step(K_IDLE, '0);            chk(1'b1, 36'hB1B1B1B1B, 1, "R8 next word");
    step(K_IDLE, '0);            chk(1'b0, '0, 0, "R8 oe low alone does not drive");
  endtask

  task automatic t_sleep;
    set_modes(1'b0, 1'b1);
    @(negedge clk);
    sleep = 1'b1; cyc_kind = K_READ; array_q = 36'hC2C2C2C2C;
    #(CLK_PERIOD/4);
    chk(1'b0, '0, 0, "R9 sleep blocks");
    sleep = 1'b0; #1;
    chk(1'b1, 36'hC2C2C2C2C, 1, "R9 wake restores");
    step(K_IDLE, '0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    t_pipe_scd();
    t_pipe_dcd();
    t_ft_scd();
    t_ft_dcd();
    t_write();
    t_oe();
    t_sleep();
    summary();
  end

endmodule